// File: doc/BRIEF.md
# Multi-operand ALU computation unit

This block is a function-unit wrapper placed between an instruction issue port, a register-file scoreboard and a pipelined ALU. When it is idle and sees an issue pulse, it latches the opcode and raises busy. It then collects each source operand it needs through its own request/grant pair and starts the ALU through a valid/ready handshake as soon as every needed operand is present. It takes the ALU result through a second valid/ready handshake and returns each valid result to the scoreboard through a request/grant pair per destination. Busy drops once the last write has completed.

There are two 16-bit sources and two 16-bit destinations. A source is not fetched in three cases: its skip bit is set at issue, it is source 0 and the zero-A flag is set, or it is source 1 and an immediate is supplied. Phases can overlap. The grant of the last operand and the ALU start can happen in the same cycle, and a write grant and the drop of busy can happen in adjacent cycles. No transaction is dropped or repeated.

Top module: `mcu_alu_unit`

## Requirements
- R1: While reset is asserted, busy_o, all rd_req_o bits, all wr_req_o bits, alu_valid_o and alu_res_ready_o are 0.
- R2: issue_i with busy_o low captures op_i, which appears on alu_op_o with busy_o high in the next cycle. issue_i while busy_o is high changes neither alu_op_o nor the request lines.
- R3: In the cycle after issue, rd_req_o bit i is 1 for each source i that is needed. The bit stays high until a cycle in which rd_gnt_i bit i is also high, and it is 0 from the next cycle on.
- R4: When zero_a_i is 1 at issue, source 0 is not requested and alu_src_o[15:0] is 0. When imm_ok_i is 1 at issue, source 1 is not requested and alu_src_o[31:16] equals imm_i.
- R5: When rd_skip_i bit i is 1 at issue, source i is not requested and its ALU operand is 0, unless R4 supplies an immediate for source 1.
- R6: alu_valid_o is 1 in the cycle in which the last outstanding read grant arrives, or in the cycle after issue if no read is needed. In that cycle alu_src_o carries the granted data (rd_data_i slice i at bits 16*i+15:16*i). alu_valid_o stays high until alu_ready_i is high and is 0 in the following cycle.
- R7: alu_res_ready_o is 1 from the cycle after the ALU accepted its input until a cycle in which alu_res_valid_i is high, and is 0 in the next cycle.
- R8: In the cycle after capture, wr_req_o bit j equals alu_res_ok_i bit j and wr_data_o slice j (bits 16*j+15:16*j) holds the captured alu_res_i slice j. Each request stays high until granted and is 0 from the next cycle.
- R9: busy_o falls in the cycle after the last write grant, or in the cycle after capture if no result was valid. A new issue is accepted in that cycle.
- R10: A read grant or write grant that arrives while the matching request is low has no effect on requests, operands or results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_i | input | 1 | Issue pulse |
| op_i | input | 8 | Opcode to capture |
| zero_a_i | input | 1 | Source 0 forced to zero |
| imm_ok_i | input | 1 | Source 1 taken from imm_i |
| imm_i | input | 16 | Immediate value |
| rd_skip_i | input | 2 | Per-source skip, sampled at issue |
| busy_o | output | 1 | Unit holds an instruction |
| rd_req_o | output | 2 | Per-source read request |
| rd_gnt_i | input | 2 | Per-source read grant |
| rd_data_i | input | 32 | Read data, 16 bits per source |
| alu_valid_o | output | 1 | ALU input valid |
| alu_ready_i | input | 1 | ALU input ready |
| alu_op_o | output | 8 | Opcode to ALU |
| alu_src_o | output | 32 | Operands to ALU, 16 bits per source |
| alu_res_valid_i | input | 1 | ALU result valid |
| alu_res_ready_o | output | 1 | Unit ready for result |
| alu_res_i | input | 32 | ALU results, 16 bits per destination |
| alu_res_ok_i | input | 2 | Per-destination result valid mark |
| wr_req_o | output | 2 | Per-destination write request |
| wr_gnt_i | input | 2 | Per-destination write grant |
| wr_data_o | output | 32 | Write data, 16 bits per destination |

## Verification
A corrupted pending bit in a source or destination slot shows up as a request that never rises, rises twice, or stays high after its grant. The bench sees this on rd_req_o or wr_req_o in the cycle after the grant. A phase register that skips or repeats a step either holds alu_valid_o high after acceptance or leaves busy_o high after the last write, both of which are visible one cycle later. Operand or result registers loaded at the wrong time put a stale or stray value on alu_src_o or wr_data_o. The bench compares these against values it computes from the stimulus.

// File: rtl/mcu_pkg.sv
package mcu_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_GATHER = 2'd1,
    PH_RESULT = 2'd2,
    PH_WRITE  = 2'd3
  } phase_e;
endpackage

// File: rtl/mcu_src_slot.sv
module mcu_src_slot #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              skip_i,
  input  logic [DATA_W-1:0] preset_i,
  input  logic              gnt_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              req_o,
  output logic              have_o,
  output logic [DATA_W-1:0] val_o
);
  logic              pend_q;
  logic [DATA_W-1:0] val_q;
  logic              take;

  assign take = pend_q & gnt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      val_q  <= '0;
    end else if (load_i) begin
      pend_q <= ~skip_i;
      val_q  <= preset_i;
    end else if (take) begin
      pend_q <= 1'b0;
      val_q  <= data_i;
    end
  end

  assign req_o  = pend_q;
  assign have_o = ~pend_q | gnt_i;
  // bypass so the ALU can start in the grant cycle
  assign val_o  = take ? data_i : val_q;

  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !gnt_i |=> req_o); // R3
  AST_RD_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && gnt_i |=> !req_o); // R3
  AST_RD_STRAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_o && !load_i |=> $stable(val_o) && !req_o); // R10
endmodule

// File: rtl/mcu_dst_slot.sv
module mcu_dst_slot #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              ok_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              gnt_i,
  output logic              req_o,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o
);
  logic              pend_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      data_q <= '0;
    end else if (load_i) begin
      pend_q <= ok_i;
      data_q <= data_i;
    end else if (pend_q && gnt_i) begin
      pend_q <= 1'b0;
    end
  end

  assign req_o  = pend_q;
  assign done_o = ~pend_q | gnt_i;
  assign data_o = data_q;

  AST_WR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !gnt_i |=> req_o && $stable(data_o)); // R8
  AST_WR_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && gnt_i && !load_i |=> !req_o); // R8
endmodule

// File: rtl/mcu_ctrl.sv
module mcu_ctrl
  import mcu_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   issue_i,
  input  logic   all_have_i,
  input  logic   alu_ready_i,
  input  logic   res_valid_i,
  input  logic   any_ok_i,
  input  logic   all_done_i,
  output phase_e phase_o,
  output logic   accept_o,
  output logic   alu_valid_o,
  output logic   res_ready_o,
  output logic   capture_o
);
  phase_e phase_q, phase_d;

  assign accept_o    = (phase_q == PH_IDLE) & issue_i;
  assign alu_valid_o = (phase_q == PH_GATHER) & all_have_i;
  assign res_ready_o = (phase_q == PH_RESULT);
  assign capture_o   = res_ready_o & res_valid_i;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:   if (issue_i) phase_d = PH_GATHER;
      PH_GATHER: if (alu_valid_o && alu_ready_i) phase_d = PH_RESULT;
      PH_RESULT: if (res_valid_i) phase_d = any_ok_i ? PH_WRITE : PH_IDLE;
      PH_WRITE:  if (all_done_i) phase_d = PH_IDLE;
      default:   phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_IDLE;
    else         phase_q <= phase_d;
  end

  assign phase_o = phase_q;

  AST_ISSUE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> phase_o != PH_IDLE); // R2
  AST_VALID_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alu_valid_o && !alu_ready_i |=> alu_valid_o); // R6
  AST_LAUNCH_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alu_valid_o && alu_ready_i |=> !alu_valid_o && res_ready_o); // R6
  AST_RES_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_o |=> !res_ready_o); // R7
endmodule

// File: rtl/mcu_alu_unit.sv
module mcu_alu_unit
  import mcu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int OP_W   = 8,
  parameter int N_SRC  = 2,
  parameter int N_DST  = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    issue_i,
  input  logic [OP_W-1:0]         op_i,
  input  logic                    zero_a_i,
  input  logic                    imm_ok_i,
  input  logic [DATA_W-1:0]       imm_i,
  input  logic [N_SRC-1:0]        rd_skip_i,
  output logic                    busy_o,
  output logic [N_SRC-1:0]        rd_req_o,
  input  logic [N_SRC-1:0]        rd_gnt_i,
  input  logic [N_SRC*DATA_W-1:0] rd_data_i,
  output logic                    alu_valid_o,
  input  logic                    alu_ready_i,
  output logic [OP_W-1:0]         alu_op_o,
  output logic [N_SRC*DATA_W-1:0] alu_src_o,
  input  logic                    alu_res_valid_i,
  output logic                    alu_res_ready_o,
  input  logic [N_DST*DATA_W-1:0] alu_res_i,
  input  logic [N_DST-1:0]        alu_res_ok_i,
  output logic [N_DST-1:0]        wr_req_o,
  input  logic [N_DST-1:0]        wr_gnt_i,
  output logic [N_DST*DATA_W-1:0] wr_data_o
);
  localparam int ZERO_SRC = 0;
  localparam int IMM_SRC  = 1;

  phase_e          phase;
  logic            accept;
  logic            capture;
  logic [N_SRC-1:0] have;
  logic [N_DST-1:0] done;
  logic [OP_W-1:0]  op_q;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    logic              skip_w;
    logic [DATA_W-1:0] preset_w;
    if (g == ZERO_SRC) begin : g_zero
      assign skip_w   = rd_skip_i[g] | zero_a_i;
      assign preset_w = '0;
    end else if (g == IMM_SRC) begin : g_imm
      assign skip_w   = rd_skip_i[g] | imm_ok_i;
      assign preset_w = imm_ok_i ? imm_i : '0;
    end else begin : g_plain
      assign skip_w   = rd_skip_i[g];
      assign preset_w = '0;
    end
    mcu_src_slot #(.DATA_W(DATA_W)) u_slot (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (accept),
      .skip_i  (skip_w),
      .preset_i(preset_w),
      .gnt_i   (rd_gnt_i[g]),
      .data_i  (rd_data_i[g*DATA_W +: DATA_W]),
      .req_o   (rd_req_o[g]),
      .have_o  (have[g]),
      .val_o   (alu_src_o[g*DATA_W +: DATA_W])
    );
  end

  for (genvar g = 0; g < N_DST; g++) begin : g_dst
    mcu_dst_slot #(.DATA_W(DATA_W)) u_slot (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .load_i(capture),
      .ok_i  (alu_res_ok_i[g]),
      .data_i(alu_res_i[g*DATA_W +: DATA_W]),
      .gnt_i (wr_gnt_i[g]),
      .req_o (wr_req_o[g]),
      .done_o(done[g]),
      .data_o(wr_data_o[g*DATA_W +: DATA_W])
    );
  end

  mcu_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .issue_i    (issue_i),
    .all_have_i (&have),
    .alu_ready_i(alu_ready_i),
    .res_valid_i(alu_res_valid_i),
    .any_ok_i   (|alu_res_ok_i),
    .all_done_i (&done),
    .phase_o    (phase),
    .accept_o   (accept),
    .alu_valid_o(alu_valid_o),
    .res_ready_o(alu_res_ready_o),
    .capture_o  (capture)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     op_q <= '0;
    else if (accept) op_q <= op_i;
  end

  assign alu_op_o = op_q;
  assign busy_o   = (phase != PH_IDLE);

  AST_REQ_NEEDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rd_req_o) || (|wr_req_o) |-> busy_o); // R9
  AST_NO_RD_AFTER_LAUNCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alu_res_ready_o |-> rd_req_o == '0); // R3
  AST_OP_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> $stable(alu_op_o)); // R2
endmodule

// File: tb/mcu_alu_unit_tb.sv
module mcu_alu_unit_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [7:0]  op;
    logic        za;
    logic        imm_ok;
    logic [15:0] imm;
    logic [1:0]  skip;
    logic [15:0] a;
    logic [15:0] b;
    logic [15:0] r0;
    logic [15:0] r1;
    logic [1:0]  ok;
  } vec_t;

  localparam vec_t VECS [0:5] = '{
    '{8'h11, 1'b0, 1'b0, 16'h0000, 2'b00, 16'h1234, 16'h5678, 16'hAAAA, 16'h5555, 2'b11},
    '{8'h22, 1'b1, 1'b0, 16'h0000, 2'b00, 16'hDEAD, 16'h0F0F, 16'h1111, 16'h2222, 2'b01},
    '{8'h33, 1'b0, 1'b1, 16'h7E57, 2'b00, 16'h3C3C, 16'hBEEF, 16'h3333, 16'h4444, 2'b10},
    '{8'h44, 1'b0, 1'b0, 16'h0000, 2'b10, 16'h0101, 16'hCAFE, 16'h6666, 16'h7777, 2'b00},
    '{8'h55, 1'b1, 1'b1, 16'h0042, 2'b00, 16'h9999, 16'h8888, 16'hA0A0, 16'h0B0B, 2'b11},
    '{8'h66, 1'b0, 1'b0, 16'h0000, 2'b11, 16'h4321, 16'h8765, 16'hC0DE, 16'hF00D, 2'b11}
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        issue = 1'b0;
  logic [7:0]  op = '0;
  logic        zero_a = 1'b0;
  logic        imm_ok = 1'b0;
  logic [15:0] imm = '0;
  logic [1:0]  rd_skip = '0;
  logic [1:0]  rd_gnt = '0;
  logic [31:0] rd_data = '0;
  logic        alu_ready = 1'b0;
  logic        res_valid = 1'b0;
  logic [31:0] res_data = '0;
  logic [1:0]  res_ok = '0;
  logic [1:0]  wr_gnt = '0;
  logic        busy, alu_valid, res_ready;
  logic [1:0]  rd_req, wr_req;
  logic [7:0]  alu_op;
  logic [31:0] alu_src, wr_data;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mcu_alu_unit u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .issue_i(issue), .op_i(op),
    .zero_a_i(zero_a), .imm_ok_i(imm_ok), .imm_i(imm), .rd_skip_i(rd_skip),
    .busy_o(busy), .rd_req_o(rd_req), .rd_gnt_i(rd_gnt), .rd_data_i(rd_data),
    .alu_valid_o(alu_valid), .alu_ready_i(alu_ready), .alu_op_o(alu_op),
    .alu_src_o(alu_src), .alu_res_valid_i(res_valid), .alu_res_ready_o(res_ready),
    .alu_res_i(res_data), .alu_res_ok_i(res_ok), .wr_req_o(wr_req),
    .wr_gnt_i(wr_gnt), .wr_data_o(wr_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic run_vec(input vec_t v);
    logic [1:0]  need;
    logic [15:0] ea, eb;
    int          last;
    need[0] = !v.za && !v.skip[0];
    need[1] = !v.imm_ok && !v.skip[1];
    ea = need[0] ? v.a : 16'h0;
    eb = need[1] ? v.b : (v.imm_ok ? v.imm : 16'h0);
    last = need[1] ? 1 : 0;
    issue = 1'b1; op = v.op; zero_a = v.za; imm_ok = v.imm_ok; imm = v.imm; rd_skip = v.skip;
    #1 chk("R2 idle before issue", {31'b0, busy}, 32'd0);
    @(negedge clk);
    issue = 1'b0; op = 8'hFF; zero_a = 1'b0; imm_ok = 1'b0; imm = 16'hFFFF; rd_skip = '0;
    #1 chk("R2 busy", {31'b0, busy}, 32'd1);
    chk("R2 opcode", {24'b0, alu_op}, {24'b0, v.op});
    chk("R3 R4 R5 rd_req", {30'b0, rd_req}, {30'b0, need});
    if (need == 2'b00) begin
      chk("R6 valid without reads", {31'b0, alu_valid}, 32'd1);
    end else begin
      for (int i = 0; i < 2; i++) begin
        if (need[i]) begin
          chk("R6 valid before last grant", {31'b0, alu_valid}, 32'd0);
          rd_gnt[i] = 1'b1;
          rd_data[i*16 +: 16] = (i == 0) ? v.a : v.b;
          #1;
          if (i == last) begin
            chk("R6 valid in grant cycle", {31'b0, alu_valid}, 32'd1);
            chk("R6 bypassed operands", alu_src, {eb, ea});
          end
          @(negedge clk);
          rd_gnt = '0; rd_data = 32'hFFFF_FFFF;
          #1 chk("R3 request drops", {31'b0, rd_req[i]}, 32'd0);
        end
      end
    end
    alu_ready = 1'b1;
    #1 chk("R6 valid held", {31'b0, alu_valid}, 32'd1);
    chk("R4 R5 R6 operands", alu_src, {eb, ea});
    @(negedge clk);
    alu_ready = 1'b0;
    #1 chk("R6 launch once", {31'b0, alu_valid}, 32'd0);
    chk("R7 ready for result", {31'b0, res_ready}, 32'd1);
    res_valid = 1'b1; res_data = {v.r1, v.r0}; res_ok = v.ok;
    @(negedge clk);
    res_valid = 1'b0; res_data = '0; res_ok = '0;
    #1 chk("R7 capture once", {31'b0, res_ready}, 32'd0);
    chk("R8 wr_req", {30'b0, wr_req}, {30'b0, v.ok});
    if (v.ok[0]) chk("R8 wr_data 0", {16'b0, wr_data[15:0]}, {16'b0, v.r0});
    if (v.ok[1]) chk("R8 wr_data 1", {16'b0, wr_data[31:16]}, {16'b0, v.r1});
    if (v.ok == 2'b00) begin
      chk("R9 busy drops without writes", {31'b0, busy}, 32'd0);
    end else begin
      for (int j = 0; j < 2; j++) begin
        if (v.ok[j]) begin
          chk("R9 busy during write", {31'b0, busy}, 32'd1);
          wr_gnt[j] = 1'b1;
          @(negedge clk);
          wr_gnt = '0;
          #1 chk("R8 write request drops", {31'b0, wr_req[j]}, 32'd0);
        end
      end
      chk("R9 busy drops after writes", {31'b0, busy}, 32'd0);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (2) @(negedge clk);
    #1 chk("R1 busy", {31'b0, busy}, 32'd0);
    chk("R1 requests", {28'b0, rd_req, wr_req}, 32'd0);
    chk("R1 handshakes", {30'b0, alu_valid, res_ready}, 32'd0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    for (int k = 0; k < 6; k++) run_vec(VECS[k]);

    // R2 issue while busy ignored; R10 stray write grants
    issue = 1'b1; op = 8'h77; zero_a = 1'b0; imm_ok = 1'b0; rd_skip = 2'b00;
    @(negedge clk);
    op = 8'h88; zero_a = 1'b1; rd_skip = 2'b11; wr_gnt = 2'b11;
    @(negedge clk);
    issue = 1'b0; wr_gnt = '0;
    #1 chk("R2 opcode kept while busy", {24'b0, alu_op}, 32'h77);
    chk("R2 requests kept while busy", {30'b0, rd_req}, 32'd3);
    // R3 R6 grant of last operand together with ALU ready
    rd_gnt = 2'b01; rd_data = 32'h0000_A1A1;
    @(negedge clk);
    rd_gnt = 2'b10; rd_data = 32'hB2B2_0000; alu_ready = 1'b1;
    #1 chk("R6 valid with last grant", {31'b0, alu_valid}, 32'd1);
    chk("R6 operands same cycle", alu_src, 32'hB2B2_A1A1);
    @(negedge clk);
    rd_gnt = 2'b11; rd_data = 32'h9999_9999; alu_ready = 1'b0;
    #1 chk("R6 no relaunch", {31'b0, alu_valid}, 32'd0);
    chk("R3 no requests after launch", {30'b0, rd_req}, 32'd0);
    @(negedge clk);
    rd_gnt = '0; rd_data = '0;
    #1 chk("R10 stray read grant", alu_src, 32'hB2B2_A1A1);
    chk("R10 no request from stray grant", {30'b0, rd_req}, 32'd0);
    res_valid = 1'b1; res_data = 32'h1357_2468; res_ok = 2'b11;
    @(negedge clk);
    res_valid = 1'b0; res_ok = '0;
    #1 chk("R10 writes still requested", {30'b0, wr_req}, 32'd3);
    chk("R8 write data", wr_data, 32'h1357_2468);
    wr_gnt = 2'b11;
    @(negedge clk);
    wr_gnt = '0;
    #1 chk("R9 busy drops after joint grant", {31'b0, busy}, 32'd0);
    // R9 back-to-back issue in the cycle busy is low
    run_vec(VECS[0]);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule